// File: doc/BRIEF.md
# Chip-Select Memory Cycle Controller

This block runs one external memory bus cycle at a time for a bank whose address has already been matched. Each bank owns an attribute word that sets the wait-state count, a relaxed-timing mode that doubles the wait states, whether the cycle is ended internally or by an external acknowledge, a setup delay from address to chip select, an early negation of chip select and write enables, and a hold-after-read option that adds an idle turnaround clock. From these the block drives an active-low chip select, an output enable for reads, four active-low byte-lane enables, a one-clock `done` pulse in the last clock of each cycle, and a one-clock `proto_err` pulse when an acknowledge arrives too late to be legal.

A requester raises `req` for one clock with a per-bank match vector, direction, region id and byte mask. The request is taken when the block is idle or in the final clock of the running cycle, so cycles can run back to back. Bank 0 comes out of reset enabled with the slowest internal timing, so a boot memory can be read before software writes any attribute. Attributes are written one bank at a time through a simple write port.

Top module: `csc_mem_cycle`

## Requirements
- R1: During and right after reset cs_n=1, oe_n=1, we_be_n=4'hF, done=0, proto_err=0; bank 0 is enabled with 15 wait states and internal termination, so a read matching only bank 0 has done high 17 clocks after the accepting edge; banks 1..3 start disabled.
- R2: Attribute word bits: [3:0] wait count W, [4] relaxed, [5] external acknowledge, [6] setup delay, [7] early negation, [8] hold after read, [9] enable. With bits 4 and 5 clear the cycle lasts 2+W clocks: done is high in clock 2+W counted from the accepting edge, for one clock.
- R3: With bit 4 set and bit 5 clear the cycle lasts 2+2W clocks.
- R4: With bit 5 set and bit 4 clear, an acknowledge sampled in clock c (c>=1) makes clock c+1 the final clock; W has no effect.
- R5: With bits 5 and 4 set, an acknowledge in clock 1 is ignored, so the shortest cycle is 3 clocks.
- R6: With bit 5 clear, an acknowledge in clock c with c <= L-2 (L the internal length) ends the cycle with final clock c+1 and no error.
- R7: With bit 5 clear, an acknowledge in clock L-1 or L raises proto_err for one clock in the following clock and the cycle keeps its full length L.
- R8: When a read on a bank with bit 8 set is followed by a request accepted in its final clock, one idle clock is inserted before the new cycle, unless the new request is a read to the same region id.
- R9: With bit 6 set cs_n stays high in clock 1; with bit 7 set cs_n and all lane enables are high in the final clock; otherwise cs_n is low in every clock of the cycle.
- R10: While cs_n is low, we_be_n equals the inverted byte mask on reads and writes; oe_n is low only on reads and only while cs_n is low.
- R11: When several enabled banks match, the lowest-index one supplies the attributes; a request matching only disabled banks is ignored.
- R12: A request arriving while a cycle is running and not in its final clock is ignored.
- R13: A write on the attribute port replaces the addressed bank's attribute word, and the next accepted cycle on that bank uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Attribute write strobe |
| cfg_bank | input | $clog2(NUM_BANKS) | Bank whose attribute word is written |
| cfg_data | input | 10 | New attribute word |
| req | input | 1 | One-clock cycle request |
| req_match | input | NUM_BANKS | Per-bank address match |
| req_rd | input | 1 | 1 for read, 0 for write |
| req_region | input | REGION_W | Region id of the access |
| req_be | input | 4 | Byte mask, bit i for lane i |
| ext_ack | input | 1 | External transfer acknowledge |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_be_n | output | 4 | Per-lane write/read enables, active low |
| done | output | 1 | High in the final clock of a cycle |
| proto_err | output | 1 | Pulse after an illegal late acknowledge |

## Verification
Cycle length is swept over all sixteen wait counts with normal and doubled timing, which separates an off-by-one in the base length from a wrong doubling. The acknowledge is placed at clocks 1, 2 and later in external mode, and at L-3, L-2, L-1 and L in internal mode, so the early-termination window edge and the ignored first-clock acknowledge under relaxed timing are each pinned down. Back-to-back pairs vary direction and region id so the turnaround is seen to appear and to be skipped. Strobe shapes are checked clock by clock with setup delay and early negation on and off, and requests to disabled or overlapping banks and mid-cycle requests show selection priority and busy rejection.

// File: rtl/csc_pkg.sv
package csc_pkg;

    parameter int WAIT_W = 4;
    parameter int LANES  = 4;

    localparam int MAX_LEN = 2 + 2 * ((1 << WAIT_W) - 1);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    typedef struct packed {
        logic              enable;
        logic              read_hold;
        logic              early_neg;
        logic              setup_dly;
        logic              ext_ack;
        logic              relax;
        logic [WAIT_W-1:0] wait_st;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);

    localparam attr_t BOOT_ATTR = '{
        enable:    1'b1,
        read_hold: 1'b0,
        early_neg: 1'b0,
        setup_dly: 1'b0,
        ext_ack:   1'b0,
        relax:     1'b0,
        wait_st:   {WAIT_W{1'b1}}
    };

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_TURN = 2'd1,
        PH_ACT  = 2'd2
    } phase_e;

endpackage

// File: rtl/csc_attr_bank.sv
module csc_attr_bank
    import csc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [BANK_W-1:0]    cfg_bank,
    input  logic [ATTR_W-1:0]    cfg_data,
    input  logic [NUM_BANKS-1:0] req_match,
    output logic                 sel_hit,
    output attr_t                sel_attr
);

    attr_t attr_d [NUM_BANKS];
    attr_t attr_q [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam attr_t RST_VAL = (b == 0) ? BOOT_ATTR : attr_t'('0);

        always_comb begin
            attr_d[b] = attr_q[b];
            if (cfg_we && (cfg_bank == BANK_W'(b))) begin
                attr_d[b] = attr_t'(cfg_data);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                attr_q[b] <= RST_VAL;
            end else begin
                attr_q[b] <= attr_d[b];
            end
        end
    end

    // Lowest-index enabled matching bank wins: scan downward so it is written last.
    always_comb begin
        sel_hit  = 1'b0;
        sel_attr = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (req_match[b] && attr_q[b].enable) begin
                sel_hit  = 1'b1;
                sel_attr = attr_q[b];
            end
        end
    end

endmodule

// File: rtl/csc_cycle_fsm.sv
module csc_cycle_fsm
    import csc_pkg::*;
#(
    parameter int REGION_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                hit,
    input  attr_t               attr_i,
    input  logic                req_rd,
    input  logic [REGION_W-1:0] req_region,
    input  logic [LANES-1:0]    req_be,
    input  logic                ext_ack,
    output logic                act_o,
    output logic                first_o,
    output logic                final_o,
    output logic                setup_o,
    output logic                early_o,
    output logic                rd_o,
    output logic [LANES-1:0]    be_o,
    output logic                err_o
);

    typedef struct packed {
        phase_e              ph;
        logic [CNT_W-1:0]    cnt;
        logic [CNT_W-1:0]    len;
        logic                fin;
        attr_t               at;
        logic                rd;
        logic [REGION_W-1:0] region;
        logic [LANES-1:0]    be;
        logic                err;
    } st_t;

    st_t st_d, st_q;

    logic             is_act;
    logic             is_final;
    logic             accept;
    logic             same_rd;
    logic             need_turn;
    logic             late_ack;
    logic             early_ok;
    logic [CNT_W-1:0] new_len;
    logic [CNT_W:0]   cnt_x;
    logic [CNT_W:0]   len_x;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;

        cnt_x    = {1'b0, st_q.cnt};
        len_x    = {1'b0, st_q.len};
        is_act   = (st_q.ph == PH_ACT);
        is_final = is_act && (st_q.fin || (!st_q.at.ext_ack && (st_q.cnt == st_q.len)));
        late_ack = (cnt_x + (CNT_W+1)'(1)) >= len_x;
        early_ok = st_q.at.ext_ack ? (!st_q.at.relax || (st_q.cnt >= CNT_W'(2))) : !late_ack;

        accept    = start && hit && ((st_q.ph == PH_IDLE) || is_final);
        same_rd   = req_rd && st_q.rd && (req_region == st_q.region);
        need_turn = is_final && st_q.rd && st_q.at.read_hold && !same_rd;
        new_len   = CNT_W'(2) + (CNT_W'(attr_i.wait_st) << attr_i.relax);

        unique case (st_q.ph)
            PH_TURN: begin
                st_d.ph  = PH_ACT;
                st_d.cnt = CNT_W'(1);
            end
            PH_ACT: begin
                if (is_final) begin
                    st_d.ph  = PH_IDLE;
                    st_d.fin = 1'b0;
                end else begin
                    if (st_q.cnt != {CNT_W{1'b1}}) begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                    if (ext_ack && early_ok) begin
                        st_d.fin = 1'b1;
                    end
                end
            end
            default: begin
            end
        endcase

        if (is_act && ext_ack && !st_q.at.ext_ack && !st_q.fin && late_ack) begin
            st_d.err = 1'b1;
        end

        if (accept) begin
            st_d.ph     = need_turn ? PH_TURN : PH_ACT;
            st_d.cnt    = CNT_W'(1);
            st_d.len    = new_len;
            st_d.fin    = 1'b0;
            st_d.at     = attr_i;
            st_d.rd     = req_rd;
            st_d.region = req_region;
            st_d.be     = req_be;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o   = is_act;
    assign first_o = (st_q.cnt == CNT_W'(1));
    assign final_o = is_final;
    assign setup_o = st_q.at.setup_dly;
    assign early_o = st_q.at.early_neg;
    assign rd_o    = st_q.rd;
    assign be_o    = st_q.be;
    assign err_o   = st_q.err;

endmodule

// File: rtl/csc_strobe_gen.sv
module csc_strobe_gen
    import csc_pkg::*;
(
    input  logic             act,
    input  logic             first,
    input  logic             last,
    input  logic             setup_dly,
    input  logic             early_neg,
    input  logic             rd,
    input  logic [LANES-1:0] be,
    output logic             cs_n,
    output logic             oe_n,
    output logic [LANES-1:0] we_be_n
);

    logic cs_on;

    always_comb begin
        cs_on   = act && !(setup_dly && first) && !(early_neg && last);
        cs_n    = !cs_on;
        oe_n    = !(cs_on && rd);
        we_be_n = cs_on ? ~be : {LANES{1'b1}};
    end

endmodule

// File: rtl/csc_mem_cycle.sv
module csc_mem_cycle
    import csc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int REGION_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [$clog2(NUM_BANKS)-1:0] cfg_bank,
    input  logic [ATTR_W-1:0]            cfg_data,
    input  logic                         req,
    input  logic [NUM_BANKS-1:0]         req_match,
    input  logic                         req_rd,
    input  logic [REGION_W-1:0]          req_region,
    input  logic [LANES-1:0]             req_be,
    input  logic                         ext_ack,
    output logic                         cs_n,
    output logic                         oe_n,
    output logic [LANES-1:0]             we_be_n,
    output logic                         done,
    output logic                         proto_err
);

    logic             sel_hit;
    attr_t            sel_attr;
    logic             act, first, last, setup_dly, early_neg, cur_rd;
    logic [LANES-1:0] cur_be;

    csc_attr_bank #(.NUM_BANKS(NUM_BANKS)) i_attr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_bank  (cfg_bank),
        .cfg_data  (cfg_data),
        .req_match (req_match),
        .sel_hit   (sel_hit),
        .sel_attr  (sel_attr)
    );

    csc_cycle_fsm #(.REGION_W(REGION_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (req),
        .hit        (sel_hit),
        .attr_i     (sel_attr),
        .req_rd     (req_rd),
        .req_region (req_region),
        .req_be     (req_be),
        .ext_ack    (ext_ack),
        .act_o      (act),
        .first_o    (first),
        .final_o    (last),
        .setup_o    (setup_dly),
        .early_o    (early_neg),
        .rd_o       (cur_rd),
        .be_o       (cur_be),
        .err_o      (proto_err)
    );

    csc_strobe_gen i_strb (
        .act       (act),
        .first     (first),
        .last      (last),
        .setup_dly (setup_dly),
        .early_neg (early_neg),
        .rd        (cur_rd),
        .be        (cur_be),
        .cs_n      (cs_n),
        .oe_n      (oe_n),
        .we_be_n   (we_be_n)
    );

    assign done = last;

endmodule

// File: rtl/csc_mem_cycle_chk.sv
module csc_mem_cycle_chk
    import csc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ext_ack,
    input logic             cs_n,
    input logic             oe_n,
    input logic [LANES-1:0] we_be_n,
    input logic             done,
    input logic             proto_err
);

    // R10
    oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !cs_n);

    // R10
    lanes_need_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_be_n != {LANES{1'b1}}) |-> !cs_n);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    err_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> $past(ext_ack));

    // R7
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> !proto_err);

endmodule

bind csc_mem_cycle csc_mem_cycle_chk i_chk (.*);

// File: tb/test_csc_mem_cycle.sv
module test_csc_mem_cycle;
    import csc_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_bank = '0;
    logic [ATTR_W-1:0] cfg_data = '0;
    logic             req = 1'b0;
    logic [3:0]       req_match = '0;
    logic             req_rd = 1'b0;
    logic [2:0]       req_region = '0;
    logic [3:0]       req_be = 4'hF;
    logic             ext_ack = 1'b0;
    logic             cs_n, oe_n, done, proto_err;
    logic [3:0]       we_be_n;

    csc_mem_cycle i_csc_mem_cycle (.*);

    always #5ns clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0, done_cnt = 0, err_cnt = 0;

    typedef struct { int s; int len; string tag; } exp_t;
    exp_t sb[$];

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard on each done pulse.
    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n) begin
            if (proto_err) err_cnt++;
            if (done) begin
                done_cnt++;
                if (sb.size() == 0) begin
                    check(1'b0, "R12 unexpected done", cyc, -1);
                end else begin
                    e = sb.pop_front();
                    check(cyc - e.s == e.len, e.tag, cyc - e.s, e.len);
                end
            end
        end
    end

    function automatic attr_t mk(bit hold, bit csnt, bit acs, bit ext, bit rlx, int w);
        attr_t a;
        a.enable = 1'b1; a.read_hold = hold; a.early_neg = csnt; a.setup_dly = acs;
        a.ext_ack = ext; a.relax = rlx; a.wait_st = WAIT_W'(w);
        return a;
    endfunction

    task automatic cfg(int b, attr_t a);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = 2'(b); cfg_data = a;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: issues one request, pushes its expected length, drives acks.
    task automatic run(string tag, logic [3:0] m, bit rd, logic [3:0] be, int len,
                       int ack1, int ack2, int busy_k, bit strb, bit acs, bit csnt, int exp_err);
        int e0; bit bad; bit cs_on; exp_t it;
        @(negedge clk);
        e0 = err_cnt;
        req = 1'b1; req_match = m; req_rd = rd; req_region = 3'd0; req_be = be;
        it.s = cyc; it.len = len; it.tag = tag;
        sb.push_back(it);
        bad = 1'b0;
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            req = (k == busy_k);
            ext_ack = (k == ack1) || (k == ack2);
            if (strb) begin
                cs_on = !(acs && k == 1) && !(csnt && k == len);
                if (cs_n !== !cs_on) bad = 1'b1;
                if (oe_n !== !(cs_on && rd)) bad = 1'b1;
                if (we_be_n !== (cs_on ? ~be : 4'hF)) bad = 1'b1;
            end
        end
        @(negedge clk);
        ext_ack = 1'b0; req = 1'b0;
        @(negedge clk);
        check(err_cnt - e0 == exp_err, {tag, " R7 error pulses"}, err_cnt - e0, exp_err);
        if (strb) check(!bad, {tag, " R9 R10 strobe shape"}, bad, 0);
    endtask

    task automatic b2b(string tag, logic [3:0] m, bit rd1, int rg1, int l1,
                       bit rd2, int rg2, int l2);
        int s1; exp_t it;
        @(negedge clk);
        s1 = cyc;
        req = 1'b1; req_match = m; req_rd = rd1; req_region = 3'(rg1);
        it.s = s1; it.len = l1; it.tag = {tag, " first"};
        sb.push_back(it);
        @(negedge clk);
        req = 1'b0;
        while (cyc != s1 + l1) @(negedge clk);
        req = 1'b1; req_rd = rd2; req_region = 3'(rg2);
        it.s = cyc; it.len = l2; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        req = 1'b0;
        repeat (l2 + 2) @(negedge clk);
    endtask

    task automatic ignored_req(string tag, logic [3:0] m);
        int d0;
        @(negedge clk);
        d0 = done_cnt;
        req = 1'b1; req_match = m; req_rd = 1'b0;
        @(negedge clk);
        req = 1'b0;
        repeat (30) @(negedge clk);
        check(done_cnt == d0, tag, done_cnt - d0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cs_n === 1'b1, "R1 cs_n in reset", cs_n, 1);
        check(oe_n === 1'b1, "R1 oe_n in reset", oe_n, 1);
        check(we_be_n === 4'hF, "R1 we_be_n in reset", we_be_n, 15);
        check(done === 1'b0 && proto_err === 1'b0, "R1 done/err in reset", done | proto_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n === 1'b1 && done === 1'b0, "R1 idle after reset", cs_n, 1);

        // R1 boot bank read
        run("R1 boot read", 4'b0001, 1'b1, 4'hF, 17, 0, 0, 0, 1'b1, 1'b0, 1'b0, 0);
        ignored_req("R1 bank2 disabled at reset", 4'b0100);

        // R2 R13 wait sweep, normal timing
        for (int w = 0; w < 16; w++) begin
            cfg(1, mk(0, 0, 0, 0, 0, w));
            run($sformatf("R2 R13 wait=%0d", w), 4'b0010, 1'b0, 4'hC, 2 + w, 0, 0, 0, 1'b0, 1'b0, 1'b0, 0);
        end
        // R3 wait sweep, relaxed timing
        for (int w = 0; w < 16; w++) begin
            cfg(1, mk(0, 0, 0, 0, 1, w));
            run($sformatf("R3 relaxed wait=%0d", w), 4'b0010, 1'b1, 4'hF, 2 + 2 * w, 0, 0, 0, 1'b0, 1'b0, 1'b0, 0);
        end

        // R4 external acknowledge
        cfg(2, mk(0, 0, 0, 1, 0, 9));
        run("R4 ext ack clk1", 4'b0100, 1'b0, 4'hF, 2, 1, 0, 0, 1'b0, 1'b0, 1'b0, 0);
        run("R4 ext ack clk4", 4'b0100, 1'b1, 4'hF, 5, 4, 0, 0, 1'b0, 1'b0, 1'b0, 0);

        // R5 external acknowledge with relaxed timing
        cfg(2, mk(0, 0, 0, 1, 1, 0));
        run("R5 ack clk1+2", 4'b0100, 1'b0, 4'hF, 3, 1, 2, 0, 1'b0, 1'b0, 1'b0, 0);
        run("R5 ack clk1 ignored", 4'b0100, 1'b0, 4'hF, 5, 1, 4, 0, 1'b0, 1'b0, 1'b0, 0);
        run("R5 ack clk2", 4'b0100, 1'b1, 4'hF, 3, 2, 0, 0, 1'b0, 1'b0, 1'b0, 0);

        // R6 R7 early acknowledge window, L=8
        cfg(1, mk(0, 0, 0, 0, 0, 6));
        run("R6 ack at L-3", 4'b0010, 1'b0, 4'hF, 6, 5, 0, 0, 1'b0, 1'b0, 1'b0, 0);
        run("R6 ack at L-2", 4'b0010, 1'b0, 4'hF, 7, 6, 0, 0, 1'b0, 1'b0, 1'b0, 0);
        run("R7 ack at L-1", 4'b0010, 1'b0, 4'hF, 8, 7, 0, 0, 1'b0, 1'b0, 1'b0, 1);
        run("R7 ack at L", 4'b0010, 1'b1, 4'hF, 8, 8, 0, 0, 1'b0, 1'b0, 1'b0, 1);

        // R9 R10 strobe shapes
        cfg(1, mk(0, 1, 1, 0, 0, 3));
        run("R9 setup+early write", 4'b0010, 1'b0, 4'b0101, 5, 0, 0, 0, 1'b1, 1'b1, 1'b1, 0);
        cfg(1, mk(0, 0, 1, 0, 0, 2));
        run("R9 setup read", 4'b0010, 1'b1, 4'b1001, 4, 0, 0, 0, 1'b1, 1'b1, 1'b0, 0);
        cfg(1, mk(0, 1, 0, 0, 0, 2));
        run("R9 early read", 4'b0010, 1'b1, 4'b1111, 4, 0, 0, 0, 1'b1, 1'b0, 1'b1, 0);
        cfg(1, mk(0, 0, 0, 0, 0, 2));
        run("R10 plain write", 4'b0010, 1'b0, 4'b0110, 4, 0, 0, 0, 1'b1, 1'b0, 1'b0, 0);

        // R8 turnaround after read
        cfg(3, mk(1, 0, 0, 0, 0, 1));
        b2b("R8 read same region", 4'b1000, 1'b1, 2, 3, 1'b1, 2, 3);
        b2b("R8 read other region", 4'b1000, 1'b1, 2, 3, 1'b1, 5, 4);
        b2b("R8 read then write", 4'b1000, 1'b1, 2, 3, 1'b0, 2, 4);
        b2b("R8 write then write", 4'b1000, 1'b0, 2, 3, 1'b0, 2, 3);
        cfg(3, mk(0, 0, 0, 0, 0, 1));
        b2b("R8 no hold read then write", 4'b1000, 1'b1, 2, 3, 1'b0, 4, 3);

        // R11 priority and disabled bank
        cfg(1, mk(0, 0, 0, 0, 0, 1));
        cfg(3, mk(0, 0, 0, 0, 0, 5));
        run("R11 lowest bank wins", 4'b1010, 1'b0, 4'hF, 3, 0, 0, 0, 1'b0, 1'b0, 1'b0, 0);
        cfg(2, attr_t'('0));
        ignored_req("R11 R13 disabled bank ignored", 4'b0100);

        // R12 mid-cycle request ignored
        cfg(1, mk(0, 0, 0, 0, 0, 4));
        run("R12 busy request", 4'b0010, 1'b0, 4'hF, 6, 0, 0, 2, 1'b0, 1'b0, 1'b0, 0);
        repeat (20) @(negedge clk);
        check(sb.size() == 0, "R12 scoreboard drained", sb.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule